// File: doc/BRIEF.md
# Debug control and status unit

This unit holds the control and status state of a small on-chip debugger that sits beside an 8-bit CPU. A debug host writes and reads two byte-wide registers: a control register and a read-only status register. The CPU decoder reports every decoded opcode with a valid strobe. The unit detects the break opcode (00h) and acts on it only when breakpoints are enabled. A break that qualifies puts the unit in debug mode, which raises a halt output that stops instruction fetch.

When the acknowledge feature is enabled, a qualifying break also raises a request to send the byte FFh to the host. This request uses a valid/ready handshake towards the serial transmitter. The host can request a system reset by writing the reset bit. That request stays up until the reset sequencer reports completion. The debugger's own state is left untouched by the system reset. A read-protect input stops the host from leaving debug mode by a register write. Under protection, only the unit's own reset clears debug mode.

Top module: `dbg_ctl_unit`

## Requirements
- R1: After rst_ni is asserted, halt_o, ack_valid_o and sys_rst_req_o are 0, and both the control register (address 0) and the status register (address 1) read 00h.
- R2: A host write to address 0 loads debug mode from bit 7, breakpoint enable from bit 6 and acknowledge enable from bit 5. The new values are visible on the next clock. halt_o equals the debug-mode bit.
- R3: With breakpoint enable at 0, a decode of opcode 00h changes nothing. A decode of any opcode other than 00h never has an effect, whatever the enables are.
- R4: With breakpoint enable at 1, a valid decode of opcode 00h sets debug mode on the next clock.
- R5: A qualifying break with acknowledge enable at 1 raises ack_valid_o with ack_data_o = FFh on the next clock. The request holds until a cycle with ack_ready_i high, and drops on the clock after that cycle. With acknowledge enable at 0, no request is raised.
- R6: A qualifying break that arrives while a request is already pending adds no second request. Exactly one handshake completes.
- R7: While rd_prot_i is 1, a host write of 0 to bit 7 is ignored and debug mode stays set. Writes to bits 6 and 5 still take effect. Status bit 5 reflects rd_prot_i.
- R8: If a host write that clears debug mode and a qualifying break occur in the same cycle, debug mode ends up set.
- R9: A write to address 0 with bit 0 set raises sys_rst_req_o on the next clock. Control bit 0 reads 1 while the request is pending. The request holds until sys_rst_done_i pulses and drops on the next clock. Debug mode and both enable bits keep their values throughout.
- R10: Control bits 4:1 always read 0. Status bit 7 shows debug mode, status bit 6 shows halt, and status bits 4:0 read 0. Writes to address 1 have no effect. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the debugger |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | AW | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | AW | Host read address |
| rd_data_o | output | 8 | Host read data (combinational) |
| dec_valid_i | input | 1 | Decoder reports an opcode this cycle |
| dec_op_i | input | 8 | Decoded opcode |
| rd_prot_i | input | 1 | Read protection active |
| halt_o | output | 1 | Stop instruction fetch |
| ack_valid_o | output | 1 | Acknowledge byte pending for the host |
| ack_data_o | output | 8 | Acknowledge byte (FFh) |
| ack_ready_i | input | 1 | Transmitter accepts the acknowledge byte |
| sys_rst_req_o | output | 1 | System reset request |
| sys_rst_done_i | input | 1 | Reset sequence finished (pulse) |

## Verification
The break path is tried with four decode patterns: opcode 00h with breakpoints disabled, non-zero opcodes with breakpoints enabled, 00h with breakpoints enabled, and 00h arriving in the same cycle as a clearing write. Together these separate the opcode compare, the enable gate and the set-over-clear priority. The acknowledge path is driven with the feature off, then with a held-off transmitter and a repeated break, which shows whether requests are dropped or queued. Debug-mode writes are repeated with protection on and off, which isolates the protect gate. The reset handshake is stretched over several cycles before the done pulse, to show that the request holds and that the other control bits persist.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int unsigned DW = 8;
  localparam logic [DW-1:0] BRK_OPCODE = 8'h00;
  localparam logic [DW-1:0] ACK_BYTE   = 8'hFF;

  // control register bit positions
  localparam int unsigned C_DBG = 7;
  localparam int unsigned C_BRK = 6;
  localparam int unsigned C_ACK = 5;
  localparam int unsigned C_RST = 0;

  // status register bit positions
  localparam int unsigned S_DBG  = 7;
  localparam int unsigned S_HALT = 6;
  localparam int unsigned S_PROT = 5;

  typedef struct packed {
    logic dbg;
    logic brk_en;
    logic ack_en;
  } ctrl_t;
endpackage

// File: rtl/dbg_brk_detect.sv
module dbg_brk_detect
  import dbg_ctl_pkg::*;
(
  input  logic          dec_valid_i,
  input  logic [DW-1:0] dec_op_i,
  input  logic          brk_en_i,
  output logic          brk_fire_o
);
  logic is_brk;
  assign is_brk     = dec_valid_i && (dec_op_i == BRK_OPCODE);
  assign brk_fire_o = is_brk && brk_en_i;
endmodule

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
  import dbg_ctl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_ctrl_i,
  input  logic  wr_dbg_i,
  input  logic  wr_brk_i,
  input  logic  wr_ack_i,
  input  logic  brk_fire_i,
  input  logic  rd_prot_i,
  output ctrl_t ctrl_o
);
  ctrl_t q, d;

  always_comb begin
    d = q;
    if (wr_ctrl_i) begin
      d.brk_en = wr_brk_i;
      d.ack_en = wr_ack_i;
      if (wr_dbg_i)        d.dbg = 1'b1;
      else if (!rd_prot_i) d.dbg = 1'b0;
    end
    // break has priority over a clearing write
    if (brk_fire_i) d.dbg = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign ctrl_o = q;
endmodule

// File: rtl/dbg_ack_req.sv
module dbg_ack_req
  import dbg_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (trig_i) pend_q <= 1'b1;
    else if (ready_i) pend_q <= 1'b0;
  end

  assign valid_o = pend_q;
  assign data_o  = ACK_BYTE;
endmodule

// File: rtl/dbg_rst_req.sv
module dbg_rst_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (set_i)  req_q <= 1'b1;
    else if (done_i) req_q <= 1'b0;
  end

  assign req_o = req_q;
endmodule

// File: rtl/dbg_ctl_unit.sv
module dbg_ctl_unit
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          dec_valid_i,
  input  logic [DW-1:0] dec_op_i,
  input  logic          rd_prot_i,
  output logic          halt_o,
  output logic          ack_valid_o,
  output logic [DW-1:0] ack_data_o,
  input  logic          ack_ready_i,
  output logic          sys_rst_req_o,
  input  logic          sys_rst_done_i
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(0);
  localparam logic [AW-1:0] STAT_ADDR = AW'(1);

  ctrl_t ctrl;
  logic  wr_ctrl, brk_fire, ack_trig, rst_set;
  logic  [3:0] rsvd_unused;

  assign wr_ctrl     = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign rst_set     = wr_ctrl && wr_data_i[C_RST];
  assign rsvd_unused = wr_data_i[4:1];

  dbg_brk_detect u_brk (
    .dec_valid_i (dec_valid_i),
    .dec_op_i    (dec_op_i),
    .brk_en_i    (ctrl.brk_en),
    .brk_fire_o  (brk_fire)
  );

  dbg_ctrl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_ctrl),
    .wr_dbg_i   (wr_data_i[C_DBG]),
    .wr_brk_i   (wr_data_i[C_BRK]),
    .wr_ack_i   (wr_data_i[C_ACK]),
    .brk_fire_i (brk_fire),
    .rd_prot_i  (rd_prot_i),
    .ctrl_o     (ctrl)
  );

  assign ack_trig = brk_fire && ctrl.ack_en;

  dbg_ack_req u_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (ack_trig),
    .ready_i (ack_ready_i),
    .valid_o (ack_valid_o),
    .data_o  (ack_data_o)
  );

  dbg_rst_req u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rst_set),
    .done_i (sys_rst_done_i),
    .req_o  (sys_rst_req_o)
  );

  assign halt_o = ctrl.dbg;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CTRL_ADDR) begin
      rd_data_o[C_DBG] = ctrl.dbg;
      rd_data_o[C_BRK] = ctrl.brk_en;
      rd_data_o[C_ACK] = ctrl.ack_en;
      rd_data_o[C_RST] = sys_rst_req_o;
    end else if (rd_addr_i == STAT_ADDR) begin
      rd_data_o[S_DBG]  = ctrl.dbg;
      rd_data_o[S_HALT] = halt_o;
      rd_data_o[S_PROT] = rd_prot_i;
    end
  end
endmodule

// File: rtl/dbg_ctl_checker.sv
module dbg_ctl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       brk_dec,
  input logic       brk_en,
  input logic       wr_ctrl,
  input logic       rst_set,
  input logic       rd_prot_i,
  input logic       halt_o,
  input logic       ack_valid_o,
  input logic [7:0] ack_data_o,
  input logic       ack_ready_i,
  input logic       sys_rst_req_o,
  input logic       sys_rst_done_i
);
  AST_BRK_SETS_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_dec && brk_en |=> halt_o); // R4
  AST_BRK_IS_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_en && !wr_ctrl |=> $stable(halt_o)); // R3
  AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && rd_prot_i |=> halt_o); // R7
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o && !ack_ready_i |=> ack_valid_o); // R5
  AST_ACK_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> ack_data_o == 8'hFF); // R5
  AST_RST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o && !sys_rst_done_i |=> sys_rst_req_o); // R9
  AST_RST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o && sys_rst_done_i && !rst_set |=> !sys_rst_req_o); // R9
endmodule

bind dbg_ctl_unit dbg_ctl_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .brk_dec        (dec_valid_i && (dec_op_i == 8'h00)),
  .brk_en         (ctrl.brk_en),
  .wr_ctrl        (wr_ctrl),
  .rst_set        (rst_set),
  .rd_prot_i      (rd_prot_i),
  .halt_o         (halt_o),
  .ack_valid_o    (ack_valid_o),
  .ack_data_o     (ack_data_o),
  .ack_ready_i    (ack_ready_i),
  .sys_rst_req_o  (sys_rst_req_o),
  .sys_rst_done_i (sys_rst_done_i)
);

// File: tb/sim_dbg_ctl_unit.sv
module sim_dbg_ctl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       dec_valid = 1'b0;
  logic [7:0] dec_op = '0;
  logic       rd_prot = 1'b0;
  logic       halt;
  logic       ack_valid;
  logic [7:0] ack_data;
  logic       ack_ready = 1'b0;
  logic       rst_req;
  logic       rst_done = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_ctl_unit #(.AW(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dec_valid_i(dec_valid), .dec_op_i(dec_op), .rd_prot_i(rd_prot),
    .halt_o(halt), .ack_valid_o(ack_valid), .ack_data_o(ack_data),
    .ack_ready_i(ack_ready), .sys_rst_req_o(rst_req),
    .sys_rst_done_i(rst_done)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic dec(input logic [7:0] op);
    @(negedge clk);
    dec_valid = 1'b1; dec_op = op;
    @(negedge clk);
    dec_valid = 1'b0; dec_op = 8'h5A;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 halt", {7'b0, halt}, 8'h00);
    chk("R1 ack_valid", {7'b0, ack_valid}, 8'h00);
    chk("R1 rst_req", {7'b0, rst_req}, 8'h00);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 stat", v, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] v;
    wr(2'd0, 8'hFE);
    chk("R2 halt set", {7'b0, halt}, 8'h01);
    rd(2'd0, v); chk("R10 ctrl rsvd", v, 8'hE0);
    rd(2'd1, v); chk("R10 stat", v, 8'hC0);
    rd(2'd2, v); chk("R10 unmapped", v, 8'h00);
    wr(2'd1, 8'h00);
    chk("R10 stat write ignored", {7'b0, halt}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R2 halt clear", {7'b0, halt}, 8'h00);
    rd(2'd0, v); chk("R2 ctrl clear", v, 8'h00);
  endtask

  task automatic t_brk_nop;
    logic [7:0] v;
    wr(2'd0, 8'h20);
    dec(8'h00);
    chk("R3 brk disabled halt", {7'b0, halt}, 8'h00);
    chk("R3 brk disabled ack", {7'b0, ack_valid}, 8'h00);
    wr(2'd0, 8'h60);
    dec(8'h01); dec(8'h80); dec(8'hFF);
    chk("R3 nonzero op halt", {7'b0, halt}, 8'h00);
    chk("R3 nonzero op ack", {7'b0, ack_valid}, 8'h00);
    rd(2'd0, v); chk("R3 ctrl", v, 8'h60);
  endtask

  task automatic t_brk_ack;
    wr(2'd0, 8'h40);
    dec(8'h00);
    chk("R4 brk sets halt", {7'b0, halt}, 8'h01);
    chk("R5 no ack when disabled", {7'b0, ack_valid}, 8'h00);
    wr(2'd0, 8'h60);
    dec(8'h00);
    chk("R5 ack raised", {7'b0, ack_valid}, 8'h01);
    chk("R5 ack byte", ack_data, 8'hFF);
    idle(3);
    chk("R5 ack held", {7'b0, ack_valid}, 8'h01);
    dec(8'h00);
    chk("R6 still one pending", {7'b0, ack_valid}, 8'h01);
    @(negedge clk); ack_ready = 1'b1;
    @(negedge clk); ack_ready = 1'b0;
    chk("R6 dropped after one handshake", {7'b0, ack_valid}, 8'h00);
    idle(3);
    chk("R6 no queued request", {7'b0, ack_valid}, 8'h00);
    wr(2'd0, 8'h00);
    chk("R2 leave debug", {7'b0, halt}, 8'h00);
  endtask

  task automatic t_prot;
    logic [7:0] v;
    rd_prot = 1'b1;
    rd(2'd1, v); chk("R7 stat prot", v, 8'h20);
    wr(2'd0, 8'h80);
    chk("R7 set under prot", {7'b0, halt}, 8'h01);
    wr(2'd0, 8'h40);
    chk("R7 clear ignored", {7'b0, halt}, 8'h01);
    rd(2'd0, v); chk("R7 enables still written", v, 8'hC0);
    rd_prot = 1'b0;
    wr(2'd0, 8'h40);
    chk("R7 clear without prot", {7'b0, halt}, 8'h00);
  endtask

  task automatic t_collide;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h40;
    dec_valid = 1'b1; dec_op = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; dec_valid = 1'b0; dec_op = 8'h5A;
    chk("R8 break beats clear", {7'b0, halt}, 8'h01);
  endtask

  task automatic t_sysrst;
    logic [7:0] v;
    wr(2'd0, 8'hE1);
    chk("R9 req raised", {7'b0, rst_req}, 8'h01);
    rd(2'd0, v); chk("R9 ctrl pending", v, 8'hE1);
    idle(4);
    chk("R9 req held", {7'b0, rst_req}, 8'h01);
    @(negedge clk); rst_done = 1'b1;
    @(negedge clk); rst_done = 1'b0;
    chk("R9 req cleared", {7'b0, rst_req}, 8'h00);
    rd(2'd0, v); chk("R9 bits kept", v, 8'hE0);
    chk("R9 halt kept", {7'b0, halt}, 8'h01);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_CYCLES) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WDOG_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_write();
    t_brk_nop();
    t_brk_ack();
    t_prot();
    t_collide();
    t_sysrst();
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule